// File: doc/BRIEF.md
# Iterative AES-128 Encryption Core

This block enciphers a single 128-bit block under a 128-bit key, spending one clock cycle per cipher round. A one-cycle start request loads the plaintext and key. The first cycle applies the key whitening. Each of the next ten cycles performs a complete round: byte substitution, row rotation, column mixing (skipped in the tenth round) and round-key addition. In parallel with each round, the next round key is derived from the current one.

The datapath has sixteen byte-substitution lookups. The key path has four more. That makes twenty lookups, all reading one constant 256-entry table that is filled in when the design is elaborated. The table is never evaluated at run time. The core takes one block at a time. A busy flag refuses new work until the result appears with a single-cycle done pulse. The result then stays on the output until the next block is accepted.

Top module: `aes128_iter_core`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: A block is accepted on a clock edge where `start` is high and `busy` is low. `done` rises exactly 11 edges after that one, counting the accepting edge as the first, and stays high for exactly one cycle.
- R3: `busy` is high from the edge after acceptance until `done` rises. `busy` and `done` are never high together.
- R4: A `start` that arrives while `busy` is high is ignored. The block in flight finishes with its own result and its own timing.
- R5: `ciphertext` equals the AES-128 encryption of `plaintext` under `cipher_key` while `done` is high. Byte 0 of each 128-bit bus is bits [127:120], and byte k sits in row k mod 4, column k div 4 of the state.
- R6: Once `done` has been seen, `ciphertext` holds its value until the next block is accepted.
- R7: A `start` given in the cycle where `done` is high is accepted at once. That block completes with the same 11-edge latency.
- R8: Round keys follow the standard schedule, with round constants 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36. The tenth round omits column mixing. Both are observable only through a correct R5 result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to encrypt the presented block |
| plaintext | input | 128 | Block to encrypt, byte 0 in bits [127:120] |
| cipher_key | input | 128 | Cipher key, byte 0 in bits [127:120] |
| busy | output | 1 | A block is being processed |
| done | output | 1 | One-cycle pulse: ciphertext is valid |
| ciphertext | output | 128 | Encrypted block, byte 0 in bits [127:120] |

## Verification
The assertions watch every cycle. They check that `done` is a one-cycle pulse arriving on the 11th edge after acceptance, that `busy` and `done` are exclusive, that an accepted start raises `busy`, and that the output is stable in idle cycles without a start.

Only the bench scenarios can show that the arithmetic is correct. The bench compares each output against a behavioural model it carries itself, using the two published vectors, a sweep of single-byte plaintexts and random blocks. The bench scenarios also show that a start arriving mid-block is dropped and that a start issued in the done cycle is taken at once.

// File: rtl/aes128_iter_core.sv
module aes128_iter_core (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [127:0] plaintext,
  input  logic [127:0] cipher_key,
  output logic         busy,
  output logic         done,
  output logic [127:0] ciphertext
);
  localparam int NB = 16;
  localparam logic [3:0] LAST = 4'd10;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [255:0][7:0] build_sbox();
    logic [255:0][7:0] t;
    logic [7:0] v, b;
    for (int i = 0; i < 256; i++) begin
      v = 8'(i);
      for (int k = 0; k < 6; k++) v = gmul(gmul(v, v), 8'(i));
      v = gmul(v, v);
      b = v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ 8'h63;
      t[i] = b;
    end
    return t;
  endfunction

  localparam logic [255:0][7:0] SBOX = build_sbox();

  logic [127:0] state_q, key_q, next_state, next_key;
  logic [3:0]   round_q;
  logic [7:0]   rcon;
  logic [7:0]   sb [NB];
  logic [7:0]   sr [NB];
  logic [7:0]   mc [NB];
  logic [31:0]  subrot;
  logic [31:0]  kw0, kw1, kw2, kw3;

  always_comb begin
    case (round_q)
      4'd1:    rcon = 8'h01;
      4'd2:    rcon = 8'h02;
      4'd3:    rcon = 8'h04;
      4'd4:    rcon = 8'h08;
      4'd5:    rcon = 8'h10;
      4'd6:    rcon = 8'h20;
      4'd7:    rcon = 8'h40;
      4'd8:    rcon = 8'h80;
      4'd9:    rcon = 8'h1b;
      4'd10:   rcon = 8'h36;
      default: rcon = 8'h00;
    endcase
  end

  genvar gi, gc, gr;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_sub
      assign sb[gi] = SBOX[state_q[127-8*gi -: 8]];
    end
    for (gc = 0; gc < 4; gc++) begin : g_col
      for (gr = 0; gr < 4; gr++) begin : g_row
        assign sr[gr + 4*gc] = sb[gr + 4*((gc + gr) % 4)];
      end
      assign mc[4*gc+0] = xt(sr[4*gc]) ^ xt(sr[4*gc+1]) ^ sr[4*gc+1] ^ sr[4*gc+2] ^ sr[4*gc+3];
      assign mc[4*gc+1] = sr[4*gc] ^ xt(sr[4*gc+1]) ^ xt(sr[4*gc+2]) ^ sr[4*gc+2] ^ sr[4*gc+3];
      assign mc[4*gc+2] = sr[4*gc] ^ sr[4*gc+1] ^ xt(sr[4*gc+2]) ^ xt(sr[4*gc+3]) ^ sr[4*gc+3];
      assign mc[4*gc+3] = xt(sr[4*gc]) ^ sr[4*gc] ^ sr[4*gc+1] ^ sr[4*gc+2] ^ xt(sr[4*gc+3]);
    end
    for (gi = 0; gi < 4; gi++) begin : g_ksub
      assign subrot[31-8*gi -: 8] = SBOX[key_q[31-8*((gi+1)%4) -: 8]];
    end
    for (gi = 0; gi < NB; gi++) begin : g_ark
      assign next_state[127-8*gi -: 8] =
        ((round_q == LAST) ? sr[gi] : mc[gi]) ^ next_key[127-8*gi -: 8];
    end
  endgenerate

  assign kw0 = key_q[127:96] ^ subrot ^ {rcon, 24'h0};
  assign kw1 = key_q[95:64] ^ kw0;
  assign kw2 = key_q[63:32] ^ kw1;
  assign kw3 = key_q[31:0]  ^ kw2;
  assign next_key = {kw0, kw1, kw2, kw3};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
      key_q   <= '0;
      round_q <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        state_q <= plaintext ^ cipher_key;
        key_q   <= cipher_key;
        round_q <= 4'd1;
        busy    <= 1'b1;
      end else if (busy) begin
        state_q <= next_state;
        key_q   <= next_key;
        round_q <= round_q + 4'd1;
        if (round_q == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign ciphertext = state_q;
endmodule

module aes128_iter_core_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [127:0] ciphertext
);
  logic [4:0] since;
  always_ff @(posedge clk) begin
    if (!rst_n) since <= '0;
    else if (start && !busy) since <= 5'd1;
    else if (busy) since <= since + 5'd1;
  end

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> (!busy && !done));
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n) done |-> since == 5'd11);
  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));
  a_r3_accept_busy: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(ciphertext));
endmodule

bind aes128_iter_core aes128_iter_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .ciphertext(ciphertext)
);

// File: tb/aes128_iter_core_bench.sv
module aes128_iter_core_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [127:0] plaintext = '0, cipher_key = '0;
  logic busy, done;
  logic [127:0] ciphertext;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  aes128_iter_core u_aes128_iter_core (
    .clk(clk), .rst_n(rst_n), .start(start), .plaintext(plaintext),
    .cipher_key(cipher_key), .busy(busy), .done(done), .ciphertext(ciphertext)
  );

  function automatic logic [7:0] r_xt(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  function automatic logic [7:0] r_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 0;
    for (int i = 7; i >= 0; i--) begin
      acc = r_xt(acc);
      if (b[i]) acc ^= a;
    end
    return acc;
  endfunction

  function automatic logic [7:0] r_sub(input logic [7:0] x);
    logic [7:0] inv = 0, y;
    for (int c = 1; c < 256; c++) if (r_mul(x, 8'(c)) == 8'h01) inv = 8'(c);
    y = 8'h63;
    for (int i = 0; i < 8; i++)
      y[i] = y[i] ^ inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
    return y;
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] p, input logic [127:0] k);
    logic [7:0] s [4][4];
    logic [7:0] t [4][4];
    logic [7:0] w [4][4];
    logic [7:0] tmp [4];
    logic [7:0] rc = 8'h01;
    logic [127:0] out;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        w[c][r] = k[127 - 8*(4*c+r) -: 8];
        s[r][c] = p[127 - 8*(4*c+r) -: 8] ^ w[c][r];
      end
    for (int rnd = 1; rnd <= 10; rnd++) begin
      for (int r = 0; r < 4; r++) tmp[r] = r_sub(w[3][(r+1)%4]);
      tmp[0] ^= rc;
      rc = r_xt(rc);
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) begin
          w[c][r] = w[c][r] ^ tmp[r];
          tmp[r] = w[c][r];
        end
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) t[r][c] = r_sub(s[r][(c+r)%4]);
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) begin
          if (rnd == 10) s[r][c] = t[r][c];
          else s[r][c] = r_mul(t[r][c], 8'h02) ^ r_mul(t[(r+1)%4][c], 8'h03)
                       ^ t[(r+2)%4][c] ^ t[(r+3)%4][c];
          s[r][c] ^= w[c][r];
        end
    end
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) out[127 - 8*(4*c+r) -: 8] = s[r][c];
    return out;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Drives at a negedge; returns at the negedge where done is first seen.
  task automatic run(input logic [127:0] p, input logic [127:0] k, input logic poke,
                     output int lat, output logic [127:0] ct);
    plaintext = p;
    cipher_key = k;
    start = 1'b1;
    lat = 0;
    ct = '0;
    while (lat < 20) begin
      @(negedge clk);
      lat++;
      start = 1'b0;
      if (poke && lat == 4) begin
        start = 1'b1;
        plaintext = ~p;
        cipher_key = ~k;
      end
      if (poke && lat == 5) start = 1'b0;
      if (done) begin
        ct = ciphertext;
        check("R3 busy low with done", {127'd0, busy}, 128'd0);
        break;
      end
    end
    plaintext = '0;
    cipher_key = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    finish_up();
  end

  initial begin
    int lat;
    logic [127:0] ct, p, k, held;
    repeat (3) @(negedge clk);
    check("R1 busy after reset", {127'd0, busy}, 128'd0);
    check("R1 done after reset", {127'd0, done}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f, 1'b0, lat, ct);
    check("R5 R8 known vector A", ct, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    check("R2 latency", 128'(lat), 128'd11);

    // R7: restart in the done cycle
    run(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c, 1'b0, lat, ct);
    check("R5 R7 known vector B", ct, 128'h3925841d02dc09fbdc118597196a0b32);
    check("R7 latency back to back", 128'(lat), 128'd11);

    @(negedge clk);
    check("R2 done one cycle", {127'd0, done}, 128'd0);
    held = ciphertext;
    repeat (4) @(negedge clk);
    check("R6 output held", ciphertext, 128'h3925841d02dc09fbdc118597196a0b32);
    check("R6 output held vs first", ciphertext, held);

    // R4: a start issued mid-block is dropped
    p = 128'h0123456789abcdeffedcba9876543210;
    k = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
    run(p, k, 1'b1, lat, ct);
    check("R4 result unaffected", ct, ref_enc(p, k));
    check("R4 latency unaffected", 128'(lat), 128'd11);
    repeat (3) @(negedge clk);
    check("R4 no second block", {127'd0, busy | done}, 128'd0);

    // sweep: a single nonzero plaintext byte in every position
    for (int b = 0; b < 16; b++) begin
      p = 128'd0;
      p[127 - 8*b -: 8] = 8'(8'hA5 + b);
      k = {16{8'(b * 17)}};
      run(p, k, 1'b0, lat, ct);
      check("R5 byte sweep", ct, ref_enc(p, k));
      check("R2 sweep latency", 128'(lat), 128'd11);
      @(negedge clk);
    end

    for (int n = 0; n < 24; n++) begin
      p = {$urandom, $urandom, $urandom, $urandom};
      k = {$urandom, $urandom, $urandom, $urandom};
      run(p, k, 1'b0, lat, ct);
      check("R5 random", ct, ref_enc(p, k));
      check("R2 random latency", 128'(lat), 128'd11);
      if (n % 2 == 0) @(negedge clk);
    end
    finish_up();
  end
endmodule